// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between the load/store stage of a processor pipeline and a 32-bit data memory that is addressed by byte. For each request it forms the effective address by adding a base register value to a signed 16-bit displacement taken from the instruction. It then checks that the access is naturally aligned for its size.

A legal store is turned into a word-aligned bus write. The write carries four byte enables, and its data is laid out in big-endian lane order. A legal load is sent to the bus the same way. Memory returns the word one clock later, and the block picks out the addressed byte, halfword or word and widens it to 32 bits, either signed or unsigned.

A misaligned request never reaches memory. Instead it raises a fault flag in the cycle in which it is presented.

Top module: `bel_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits, with wrap-around modulo 2^32. `mem_addr` is that address with its two low bits cleared.
- R2: `req_size` selects the access size: 0 = byte, 1 = halfword, 2 = word. A byte access is legal at any address. A halfword access is legal when the address is even. A word access is legal when the address is a multiple of four.
- R3: A request that is misaligned, or that uses size code 3, drives `fault` high in that cycle. In that cycle `mem_req` and `mem_we` stay low and `mem_be` is zero, so no memory byte changes.
- R4: Byte lanes are big-endian. `mem_be[3]` enables bits 31:24, which is address offset 0, and `mem_be[0]` enables bits 7:0, which is offset 3. A byte access at offset k drives `4'b1000 >> k`. A halfword access drives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word access drives 4'b1111.
- R5: On a legal store, `mem_we` is high. `mem_wdata` carries the low byte of `req_wdata` in all four lanes for a byte store, and the low halfword in both halves for a halfword store. For a word store it carries `req_wdata` unchanged. As a result, storing word 0x11223344 at address 100 places 0x11, 0x22, 0x33 and 0x44 at addresses 100 to 103.
- R6: On a legal load, `mem_req` is high, `mem_we` is low, and `mem_be` marks the lanes that are read.
- R7: With `req_unsigned` low, a loaded byte or halfword is sign-extended to 32 bits. The most significant byte of a halfword comes from the lower address.
- R8: With `req_unsigned` high, a loaded byte or halfword is zero-extended to 32 bits.
- R9: `ld_valid` is high for exactly one cycle, the cycle after a legal load request, when `mem_rvalid` returns. It is never high after a store or after a faulted request.
- R10: After a synchronous active-low reset, `ld_valid` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned | input | 1 | Zero-extend load result |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| fault | output | 1 | Misaligned or reserved-size request |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 32 | Word-aligned bus address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rvalid | input | 1 | Read data valid, one clock after request |
| mem_rdata | input | 32 | Read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench stores a known word and then reads it back in several ways: byte loads at each lane, halfword loads at both halves, and word loads. A value with its top bit set separates signed from unsigned extension. Displacements that are negative or that wrap the base past 2^32 separate a correct sign-extension from a plain add. Halfword accesses at odd offsets, word accesses at offset 2, and size code 3 each have to fault. After each fault a readback shows that memory was not disturbed, and the response stream shows that no stray load result appeared.

// File: rtl/bel_pkg.sv
package bel_pkg;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam int DSPW  = 16;
  localparam int NLANE = DW / 8;
  localparam int OFFW  = $clog2(NLANE);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  // base plus sign-extended displacement, modulo 2^AW
  function automatic logic [AW-1:0] eff_addr(input logic [AW-1:0] b,
                                              input logic [DSPW-1:0] d);
    logic [AW-1:0] dx;
    dx = {{(AW-DSPW){d[DSPW-1]}}, d};
    return b + dx;
  endfunction

  function automatic logic misaligned(input size_e s, input logic [OFFW-1:0] o);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return o[0];
      SZ_WORD: return |o;
      default: return 1'b1;
    endcase
  endfunction

  // lane NLANE-1 of the mask is address offset 0 (most significant bits)
  function automatic logic [NLANE-1:0] lane_mask(input size_e s,
                                                  input logic [OFFW-1:0] o);
    logic [NLANE-1:0] m;
    m = '0;
    case (s)
      SZ_BYTE: begin m[NLANE-1] = 1'b1; m = m >> o; end
      SZ_HALF: begin m[NLANE-1 -: 2] = 2'b11; m = m >> o; end
      SZ_WORD: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] place_wdata(input size_e s,
                                                 input logic [DW-1:0] d);
    case (s)
      SZ_BYTE: return {NLANE{d[7:0]}};
      SZ_HALF: return {(NLANE/2){d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] extract(input size_e s, input logic uns,
                                             input logic [OFFW-1:0] o,
                                             input logic [DW-1:0] rd);
    logic [7:0]  b;
    logic [15:0] h;
    int top;
    top = DW - 1 - 8 * int'(o);
    b = rd[top -: 8];
    h = rd[top -: 16];
    case (s)
      SZ_BYTE: return {{(DW-8){b[7] & ~uns}}, b};
      SZ_HALF: return {{(DW-16){h[15] & ~uns}}, h};
      default: return rd;
    endcase
  endfunction
endpackage

// File: rtl/bel_agen.sv
module bel_agen
  import bel_pkg::*;
(
  input  logic [AW-1:0]   base,
  input  logic [DSPW-1:0] disp,
  input  size_e           size,
  output logic [AW-1:0]   ea,
  output logic [OFFW-1:0] off,
  output logic            misalign
);
  always_comb begin
    ea       = eff_addr(base, disp);
    off      = ea[OFFW-1:0];
    misalign = misaligned(size, off);
  end
endmodule

// File: rtl/bel_wpath.sv
module bel_wpath
  import bel_pkg::*;
(
  input  logic             enable,
  input  size_e            size,
  input  logic [OFFW-1:0]  off,
  input  logic [DW-1:0]    wdata_in,
  output logic [NLANE-1:0] be,
  output logic [DW-1:0]    wdata_out
);
  always_comb begin
    be        = enable ? lane_mask(size, off) : '0;
    wdata_out = place_wdata(size, wdata_in);
  end
endmodule

// File: rtl/bel_rpath.sv
module bel_rpath
  import bel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_load,
  input  size_e           size,
  input  logic            uns,
  input  logic [OFFW-1:0] off,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            ld_valid,
  output logic [DW-1:0]   ld_data
);
  logic            pend_q;
  size_e           size_q;
  logic            uns_q;
  logic [OFFW-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      size_q <= SZ_BYTE;
      uns_q  <= 1'b0;
      off_q  <= '0;
    end else begin
      pend_q <= issue_load;
      if (issue_load) begin
        size_q <= size;
        uns_q  <= uns;
        off_q  <= off;
      end
    end
  end

  always_comb begin
    ld_valid = pend_q & mem_rvalid;
    ld_data  = ld_valid ? extract(size_q, uns_q, off_q, mem_rdata) : '0;
  end

  // R9: a result only ever follows a load issued one cycle before
  a_r9_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(issue_load));
  // R10: output quiet when nothing is returned
  a_r10_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> ld_data == '0);
endmodule

// File: rtl/bel_lsu.sv
module bel_lsu
  import bel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic [31:0] req_base,
  input  logic [15:0] req_disp,
  input  logic [31:0] req_wdata,
  output logic        fault,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        ld_valid,
  output logic [31:0] ld_data
);
  size_e           size;
  logic [AW-1:0]   ea;
  logic [OFFW-1:0] off;
  logic            misalign;
  logic            legal;
  logic            issue_load;

  assign size = size_e'(req_size);

  bel_agen u_agen (
    .base(req_base), .disp(req_disp), .size(size),
    .ea(ea), .off(off), .misalign(misalign)
  );

  assign fault      = req_valid & misalign;
  assign legal      = req_valid & ~misalign;
  assign issue_load = legal & ~req_store;
  assign mem_req    = legal;
  assign mem_we     = legal & req_store;
  assign mem_addr   = {ea[AW-1:OFFW], {OFFW{1'b0}}};

  bel_wpath u_wpath (
    .enable(legal), .size(size), .off(off), .wdata_in(req_wdata),
    .be(mem_be), .wdata_out(mem_wdata)
  );

  bel_rpath u_rpath (
    .clk(clk), .rst_n(rst_n), .issue_load(issue_load), .size(size),
    .uns(req_unsigned), .off(off), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // R3: a faulted request leaves the bus idle
  a_r3_fault_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_req && !mem_we && mem_be == 4'b0000));
  // R1: bus address is always word aligned
  a_r1_bus_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R4: enables cover 1, 2 or 4 lanes
  a_r4_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 $countones(mem_be) == 4));
  // R2: a word request that reaches the bus enables every lane
  a_r2_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'd2) |-> mem_be == 4'b1111);
  // R6: no enables without a request
  a_r6_be_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> mem_be == 4'b0000);
endmodule

// File: tb/sim_bel_lsu.sv
module sim_bel_lsu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_store = 0, req_unsigned = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_base = 0, req_wdata = 0;
  logic [15:0] req_disp = 0;
  logic        fault, mem_req, mem_we, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] bytes [256];
  logic [31:0] expq [$];
  string       tagq [$];

  always #2.5 clk = ~clk;

  bel_lsu u0 (.*);

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      for (int k = 0; k < 4; k++)
        if (mem_we && mem_be[3-k]) bytes[mem_addr[7:0] + 8'(k)] <= mem_wdata[31-8*k -: 8];
      if (!mem_we) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= {bytes[mem_addr[7:0]], bytes[mem_addr[7:0]+8'd1],
                       bytes[mem_addr[7:0]+8'd2], bytes[mem_addr[7:0]+8'd3]};
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a load result appears
  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      if (expq.size() == 0) chk("R9 stray ld_valid", 32'd1, 32'd0);
      else chk(tagq.pop_front(), ld_data, expq.pop_front());
    end
  end

  function automatic logic [31:0] ref_load(logic [31:0] a, int sz, bit uns);
    logic [31:0] v;
    if (sz == 0) v = uns ? {24'd0, bytes[a[7:0]]} : 32'(signed'(bytes[a[7:0]]));
    else if (sz == 1) begin
      v = {16'd0, bytes[a[7:0]], bytes[a[7:0]+8'd1]};
      if (!uns && v[15]) v[31:16] = 16'hFFFF;
    end else v = {bytes[a[7:0]], bytes[a[7:0]+8'd1], bytes[a[7:0]+8'd2], bytes[a[7:0]+8'd3]};
    return v;
  endfunction

  // driver: presents one request, checks the bus side, queues load results
  task automatic op(string req, bit st, int sz, bit uns, logic [31:0] b,
                    logic [15:0] d, logic [31:0] wd, bit exp_fault,
                    logic [3:0] exp_be);
    logic [31:0] a;
    a = b + {{16{d[15]}}, d};
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = 2'(sz); req_unsigned = uns;
    req_base = b; req_disp = d; req_wdata = wd;
    #1;
    chk({req, " fault"}, {31'd0, fault}, {31'd0, exp_fault});
    chk({req, " be"}, {28'd0, mem_be}, {28'd0, exp_be});
    chk({req, " req"}, {31'd0, mem_req}, {31'd0, !exp_fault});
    if (!exp_fault) begin
      chk({req, " R1 addr"}, mem_addr, {a[31:2], 2'b00});
      chk({req, " R6 we"}, {31'd0, mem_we}, {31'd0, st});
      if (!st) begin
        expq.push_back(ref_load(a, sz, uns));
        tagq.push_back({req, " load data"});
      end
    end
  endtask

  task automatic idle(int n);
    @(negedge clk); req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bytes[i] = 8'(i * 7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ld_valid after reset", {31'd0, ld_valid}, 32'd0);
    chk("R10 ld_data after reset", ld_data, 32'd0);
    rst_n = 1;

    op("R5 word store", 1, 2, 0, 32'd96, 16'd4, 32'h11223344, 0, 4'b1111);
    idle(1);
    chk("R5 byte@100", {24'd0, bytes[100]}, 32'h11);
    chk("R5 byte@101", {24'd0, bytes[101]}, 32'h22);
    chk("R5 byte@102", {24'd0, bytes[102]}, 32'h33);
    chk("R5 byte@103", {24'd0, bytes[103]}, 32'h44);

    op("R4 byte store off2", 1, 0, 0, 32'd100, 16'd2, 32'h000000C0, 0, 4'b0010);
    chk("R5 byte replicated", mem_wdata, 32'hC0C0C0C0);
    op("R7 byte load off1", 0, 0, 0, 32'd101, 16'd0, 0, 0, 4'b0100);
    op("R7 signed byte off2", 0, 0, 0, 32'd100, 16'd2, 0, 0, 4'b0010);
    op("R8 unsigned byte off2", 0, 0, 1, 32'd100, 16'd2, 0, 0, 4'b0010);
    op("R7 signed half off2", 0, 1, 0, 32'd100, 16'd2, 0, 0, 4'b0011);
    op("R8 unsigned half off2", 0, 1, 1, 32'd100, 16'd2, 0, 0, 4'b0011);
    op("R7 half off0", 0, 1, 0, 32'd100, 16'd0, 0, 0, 4'b1100);
    op("R1 negative disp word", 0, 2, 0, 32'd110, 16'hFFF6, 0, 0, 4'b1111);
    op("R4 byte load off3", 0, 0, 1, 32'd103, 16'd0, 0, 0, 4'b0001);
    op("R4 byte load off0", 0, 0, 1, 32'd100, 16'd0, 0, 0, 4'b1000);
    idle(2);

    op("R3 half at odd", 1, 1, 0, 32'd100, 16'd1, 32'h0000FFFF, 1, 4'b0000);
    op("R3 word at off2", 1, 2, 0, 32'd100, 16'd2, 32'hDEADBEEF, 1, 4'b0000);
    op("R3 reserved size", 1, 3, 0, 32'd100, 16'd0, 32'hDEADBEEF, 1, 4'b0000);
    op("R9 faulted load", 0, 2, 0, 32'd101, 16'd0, 0, 1, 4'b0000);
    idle(2);
    chk("R3 mem untouched", {bytes[100], bytes[101], bytes[102], bytes[103]}, 32'h1122C044);
    op("R3 readback word", 0, 2, 0, 32'd100, 16'd0, 0, 0, 4'b1111);

    op("R5 half store off2", 1, 1, 0, 32'd98, 16'd4, 32'h1234ABCD, 0, 4'b0011);
    chk("R5 half replicated", mem_wdata, 32'hABCDABCD);
    op("R5 half readback", 0, 1, 1, 32'd102, 16'd0, 0, 0, 4'b0011);
    op("R1 wrap past 2^32", 0, 2, 0, 32'hFFFFFFF0, 16'h0014, 0, 0, 4'b1111);
    chk("R1 wrap addr", mem_addr, 32'h00000004);
    idle(3);
    chk("R9 queue drained", 32'(expq.size()), 32'd0);
    chk("R9 ld_valid idle", {31'd0, ld_valid}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule